// File: doc/BRIEF.md
# Cached-Head Ring FIFO

This block is a four-deep first-in first-out queue for small data words. The oldest entry always sits in a dedicated head register, so it can be offered on the output the cycle after it is known. The remaining entries are parked in a ring of three storage cells. The controller reaches each cell only through a blocking request/acknowledge write port and a request/acknowledge read port.

Producers push words through a valid/ready input, and consumers take them through a valid/ready output. A word arriving at an empty queue goes straight into the head register. A word arriving at a non-empty queue is written into the cell named by the top pointer. When the head is consumed and more words remain, the controller refills the head from the cell named by the bottom pointer. Both pointers run over 1..3 and advance as (p mod 3) + 1. Only one handshake with a cell is in flight at any time. While one is in flight, the block neither accepts nor offers data.

Top module: `ring_fifo_top`

## Requirements
- R1: After synchronous reset the queue is empty: `out_valid` is 0 and `in_ready` is 1.
- R2: The queue holds at most four words. With four words stored, `in_ready` stays 0 until a word leaves.
- R3: Words leave in the order they were accepted, including after the ring pointers have wrapped many times.
- R4: `out_valid` is 1 only while the queue is non-empty and no cell handshake is running. `out_data` is always the oldest stored word and does not change while the consumer stalls.
- R5: A word accepted into an empty queue is offered on the output in the very next cycle, with no cell access.
- R6: A word accepted into a non-empty queue starts a cell write. For the two cycles that follow, `in_ready` and `out_valid` are both 0. In the third cycle the block is idle again.
- R7: Taking a word while two or more are stored starts a cell refill. For the two cycles that follow, `out_valid` is 0. In the third cycle the next word is offered.
- R8: Taking the only stored word empties the queue without any cell access. In the next cycle `out_valid` is 0 and `in_ready` is 1.
- R9: When an output transfer can happen (`out_valid` and `out_ready` both 1), `in_ready` is 0. The output wins over a simultaneous input.
- R10: A storage cell acknowledges only a request that was present in the previous cycle. At most one cell acknowledge is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | DATA_W | Word to enqueue |
| out_valid | output | 1 | `out_data` holds the oldest word |
| out_ready | input | 1 | Consumer takes `out_data` this cycle |
| out_data | output | DATA_W | Oldest stored word |

## Verification
On every cycle, the assertions check:
- the occupancy bound and the stall when full;
- silence on the output when empty;
- stability of the offered head under back-pressure;
- output-over-input priority;
- the busy window after a ring write;
- direct loading of the head and the empty state after the last word;
- cell acknowledge causality and exclusivity.

Only the bench scenarios can show the following:
- the exact length of the refill gap;
- end-to-end word order across repeated pointer wraps under irregular consumer stalls;
- that the queue drains completely.

// File: rtl/ring_fifo_pkg.sv
`timescale 1ns/1ps
package ring_fifo_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WRITE  = 2'd1,
      ST_REFILL = 2'd2
   } ctrl_st_t;
endpackage

// File: rtl/ring_cell.sv
`timescale 1ns/1ps
// One ring storage slot: alternates store (write handshake) and give back
// (read handshake). Acknowledges are registered, one cycle after the request.
module ring_cell #(
   parameter int DATA_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ack,
   input  logic              rd_req,
   output logic              rd_ack,
   output logic [DATA_W-1:0] rd_data
);
   logic              full_q;
   logic [DATA_W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         val_q  <= '0;
         wr_ack <= 1'b0;
         rd_ack <= 1'b0;
      end else begin
         wr_ack <= 1'b0;
         rd_ack <= 1'b0;
         if (!full_q && wr_req) begin
            val_q  <= wr_data;
            full_q <= 1'b1;
            wr_ack <= 1'b1;
         end else if (full_q && rd_req) begin
            full_q <= 1'b0;
            rd_ack <= 1'b1;
         end
      end
   end

   assign rd_data = val_q;
endmodule

// File: rtl/ring_ctrl.sv
`timescale 1ns/1ps
// Sequencer: keeps the head word, occupancy and the two 1-based ring pointers.
module ring_ctrl
   import ring_fifo_pkg::*;
#(
   parameter int DATA_W = 2,
   parameter int CELLS  = 3,
   localparam int CAP   = CELLS + 1,
   localparam int PTR_W = $clog2(CELLS + 1),
   localparam int CNT_W = $clog2(CAP + 1)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [DATA_W-1:0]             in_data,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [DATA_W-1:0]             out_data,
   output logic [CNT_W-1:0]              occ,
   output logic [CELLS-1:0]              cell_wr_req,
   output logic [DATA_W-1:0]             cell_wr_data,
   input  logic [CELLS-1:0]              cell_wr_ack,
   output logic [CELLS-1:0]              cell_rd_req,
   input  logic [CELLS-1:0]              cell_rd_ack,
   input  logic [CELLS-1:0][DATA_W-1:0]  cell_rd_data
);
   localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(CELLS);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(CAP);

   ctrl_st_t          st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PTR_W-1:0]  top_q, bot_q, top_ix, bot_ix;
   logic [DATA_W-1:0] head_q, wbuf_q;
   logic              in_fire, out_fire, idle, wr_done, rd_done;

   function automatic logic [PTR_W-1:0] ring_adv(input logic [PTR_W-1:0] p);
      return (p == PTR_LAST) ? PTR_ONE : p + PTR_ONE;
   endfunction

   assign idle      = (st_q == ST_IDLE);
   assign out_valid = idle && (cnt_q != '0);
   assign out_fire  = out_valid && out_ready;
   assign in_ready  = idle && (cnt_q < CNT_CAP) && !out_fire;
   assign in_fire   = in_valid && in_ready;
   assign out_data  = head_q;
   assign occ       = cnt_q;

   assign top_ix       = top_q - PTR_ONE;
   assign bot_ix       = bot_q - PTR_ONE;
   assign cell_wr_data = wbuf_q;
   assign wr_done      = (st_q == ST_WRITE)  && cell_wr_ack[top_ix];
   assign rd_done      = (st_q == ST_REFILL) && cell_rd_ack[bot_ix];

   always_comb begin
      for (int i = 0; i < CELLS; i++) begin
         cell_wr_req[i] = (st_q == ST_WRITE)  && (top_ix == PTR_W'(i));
         cell_rd_req[i] = (st_q == ST_REFILL) && (bot_ix == PTR_W'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         top_q  <= PTR_ONE;
         bot_q  <= PTR_ONE;
         head_q <= '0;
         wbuf_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (out_fire) begin
                  if (cnt_q > CNT_ONE) st_q  <= ST_REFILL;
                  else                 cnt_q <= '0;
               end else if (in_fire) begin
                  if (cnt_q == '0) begin
                     head_q <= in_data;
                     cnt_q  <= CNT_ONE;
                  end else begin
                     wbuf_q <= in_data;
                     st_q   <= ST_WRITE;
                  end
               end
            end
            ST_WRITE: begin
               if (wr_done) begin
                  cnt_q <= cnt_q + CNT_ONE;
                  top_q <= ring_adv(top_q);
                  st_q  <= ST_IDLE;
               end
            end
            ST_REFILL: begin
               if (rd_done) begin
                  head_q <= cell_rd_data[bot_ix];
                  cnt_q  <= cnt_q - CNT_ONE;
                  bot_q  <= ring_adv(bot_q);
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ring_fifo_top.sv
`timescale 1ns/1ps
module ring_fifo_top #(
   parameter int DATA_W = 2,
   parameter int CELLS  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   localparam int CNT_W = $clog2(CELLS + 2);

   if (CELLS < 1) begin : g_bad_cells
      $error("ring_fifo_top: CELLS must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ring_fifo_top: DATA_W must be at least 1");
   end

   logic [CNT_W-1:0]             occ;
   logic [CELLS-1:0]             wr_req_v, wr_ack_v, rd_req_v, rd_ack_v;
   logic [DATA_W-1:0]            wr_data_w;
   logic [CELLS-1:0][DATA_W-1:0] rd_data_v;

   ring_ctrl #(.DATA_W(DATA_W), .CELLS(CELLS)) i_ctrl (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_data      (in_data),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_data     (out_data),
      .occ          (occ),
      .cell_wr_req  (wr_req_v),
      .cell_wr_data (wr_data_w),
      .cell_wr_ack  (wr_ack_v),
      .cell_rd_req  (rd_req_v),
      .cell_rd_ack  (rd_ack_v),
      .cell_rd_data (rd_data_v)
   );

   for (genvar i = 0; i < CELLS; i++) begin : g_cell
      ring_cell #(.DATA_W(DATA_W)) i_cell (
         .clk     (clk),
         .rst     (rst),
         .wr_req  (wr_req_v[i]),
         .wr_data (wr_data_w),
         .wr_ack  (wr_ack_v[i]),
         .rd_req  (rd_req_v[i]),
         .rd_ack  (rd_ack_v[i]),
         .rd_data (rd_data_v[i])
      );
   end
endmodule

// File: rtl/ring_fifo_chk.sv
`timescale 1ns/1ps
module ring_fifo_chk #(
   parameter int DATA_W = 2,
   parameter int CELLS  = 3,
   localparam int CAP   = CELLS + 1,
   localparam int CNT_W = $clog2(CAP + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic [CNT_W-1:0]  occ,
   input logic [CELLS-1:0]  wr_req_v,
   input logic [CELLS-1:0]  wr_ack_v,
   input logic [CELLS-1:0]  rd_ack_v
);
   // R2
   occ_cap_chk: assert property (@(posedge clk) disable iff (rst)
      occ <= CNT_W'(CAP));
   // R2
   full_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (occ == CNT_W'(CAP)) |-> !in_ready);
   // R4
   empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (occ == '0) |-> !out_valid);
   // R4
   head_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> $stable(out_data));
   // R5
   fill_direct_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && occ == '0) |=> (out_valid && out_data == $past(in_data)));
   // R6
   write_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && occ != '0) |=> (!in_ready && !out_valid));
   // R8
   last_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && occ == CNT_W'(1)) |=> (occ == '0 && in_ready));
   // R9
   out_first_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready) |-> !in_ready);
   // R10
   wr_ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ack_v & ~$past(wr_req_v)) == '0);
   // R10
   one_ack_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({wr_ack_v, rd_ack_v}));
endmodule

bind ring_fifo_top ring_fifo_chk #(.DATA_W(DATA_W), .CELLS(CELLS)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .occ       (occ),
   .wr_req_v  (wr_req_v),
   .wr_ack_v  (wr_ack_v),
   .rd_ack_v  (rd_ack_v)
);

// File: tb/test_ring_fifo_top.sv
`timescale 1ns/1ps
module test_ring_fifo_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic       out_ready = 1'b0;
   logic [1:0] in_data = 2'd0;
   logic       in_ready, out_valid;
   logic [1:0] out_data;

   int         total = 0;
   int         bad = 0;
   logic [1:0] exp_q[$];
   logic [1:0] mon_exp;
   bit         sending;
   logic [7:0] lfsr = 8'hA5;

   always #2.5 clk = ~clk;

   ring_fifo_top #(.DATA_W(2), .CELLS(3)) i_ring_fifo_top (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Driver: called at a falling edge, holds the word until accepted, logs it.
   task automatic send(input logic [1:0] v);
      in_valid = 1'b1;
      in_data  = v;
      #2;
      while (!in_ready) begin
         @(negedge clk);
         #2;
      end
      exp_q.push_back(v);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor: sampled 2 ns after each falling edge, before the next rising edge.
   always @(negedge clk) begin
      #2;
      if (!rst && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3 output with empty scoreboard", int'(out_data), -1);
         end else begin
            mon_exp = exp_q.pop_front();
            chk(out_data == mon_exp, "R3 word order", int'(out_data), int'(mon_exp));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #2;
      chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);

      // R5 then R8: load an empty queue, take the single word
      @(negedge clk);
      send(2'd2);
      #2;
      chk(out_valid == 1'b1, "R5 direct head valid", int'(out_valid), 1);
      chk(out_data == 2'd2, "R5 direct head data", int'(out_data), 2);
      @(negedge clk);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      #2;
      chk(out_valid == 1'b0, "R8 empty after last", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R8 ready after last", int'(in_ready), 1);

      // R6: write into the ring while one word is held
      @(negedge clk);
      send(2'd1);
      in_valid = 1'b1;
      in_data  = 2'd3;
      #2;
      chk(in_ready == 1'b1, "R6 accept second", int'(in_ready), 1);
      exp_q.push_back(2'd3);
      @(negedge clk);
      in_valid = 1'b0;
      #2;
      chk(in_ready == 1'b0, "R6 busy cycle 1 ready", int'(in_ready), 0);
      chk(out_valid == 1'b0, "R6 busy cycle 1 valid", int'(out_valid), 0);
      @(negedge clk);
      #2;
      chk(in_ready == 1'b0, "R6 busy cycle 2 ready", int'(in_ready), 0);
      @(negedge clk);
      #2;
      chk(in_ready == 1'b1, "R6 idle again", int'(in_ready), 1);
      chk(out_valid == 1'b1 && out_data == 2'd1, "R6 head kept", int'(out_data), 1);

      // R2 and R4: fill to four words, then push once more
      @(negedge clk);
      send(2'd2);
      send(2'd1);
      in_valid = 1'b1;
      in_data  = 2'd3;
      #2;
      chk(in_ready == 1'b0, "R2 full blocks input", int'(in_ready), 0);
      chk(out_data == 2'd1, "R4 head is oldest", int'(out_data), 1);
      @(negedge clk);
      #2;
      chk(in_ready == 1'b0, "R2 still full", int'(in_ready), 0);
      @(negedge clk);
      in_valid = 1'b0;

      // R7: take one word with three left, watch the refill gap
      out_ready = 1'b1;
      #2;
      chk(out_valid == 1'b1, "R7 offer before refill", int'(out_valid), 1);
      @(negedge clk);
      out_ready = 1'b0;
      #2;
      chk(out_valid == 1'b0, "R7 refill gap 1", int'(out_valid), 0);
      @(negedge clk);
      #2;
      chk(out_valid == 1'b0, "R7 refill gap 2", int'(out_valid), 0);
      @(negedge clk);
      #2;
      chk(out_valid == 1'b1 && out_data == 2'd3, "R7 refilled head", int'(out_data), 3);

      // R9: input and output both possible in the same cycle
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = 2'd2;
      out_ready = 1'b1;
      #2;
      chk(in_ready == 1'b0, "R9 output wins", int'(in_ready), 0);
      @(negedge clk);
      in_valid  = 1'b0;

      // drain the rest
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         #2;
         if (exp_q.size() == 0 && !out_valid) break;
      end
      chk(exp_q.size() == 0, "R3 first drain complete", exp_q.size(), 0);
      @(negedge clk);
      out_ready = 1'b0;

      // R3 and R10: long stream with irregular stalls, many pointer wraps
      sending = 1'b1;
      fork
         begin
            for (int i = 0; i < 40; i++) send(2'(((i + i / 3) % 3) + 1));
            sending = 1'b0;
         end
         begin
            while (sending) begin
               @(negedge clk);
               lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
               out_ready = lfsr[0] & lfsr[2];
            end
         end
      join
      @(negedge clk);
      out_ready = 1'b1;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         #2;
         if (exp_q.size() == 0 && !out_valid) break;
      end
      chk(exp_q.size() == 0, "R3 R10 stream fully delivered", exp_q.size(), 0);
      chk(in_ready == 1'b1, "R3 idle after drain", int'(in_ready), 1);
      @(negedge clk);
      out_ready = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule